// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It brings the memory device from power-on to its ready state. A start pulse taken while the block is idle begins a long settling interval. Through that interval the clock-enable output is held low and only NOP is presented. The block then raises clock enable and plays a fixed command script. The script covers two all-bank precharges, the extended and base mode-register loads with the DLL reset, two refreshes, and an optional load that clears the DLL-reset bit. Each command has its own minimum spacing.

Every wait is a parameter given in clock cycles. A single down-counter times them all, and it is reloaded whenever the state machine enters a wait state. A command is driven for one cycle only, and NOP fills every other cycle. The sequence closes with a done flag. It means the device may now take any normal command. The flag stays high until a synchronous reset.

States and transitions:
- `S_IDLE` goes to `S_PWR_WAIT` on start.
- `S_PWR_WAIT` goes to `S_CKE_ON` when the timer expires.
- `S_CKE_ON` is followed by `S_PRE1`, then `S_W_RP1`, then `S_LD_EMR`.
- `S_LD_EMR` is followed by `S_W_MRD1`, then `S_LD_MR_RST`, then `S_W_MRD2`.
- `S_W_MRD2` leads to `S_PRE2`, then `S_W_RP2`, then `S_REF1`.
- `S_REF1` is followed by `S_W_RFC1`, then `S_REF2`, then `S_W_RFC2`.
- `S_W_RFC2` goes to `S_LD_MR_CLR` if the clear option was latched, and otherwise to `S_READY`.
- `S_LD_MR_CLR` is followed by `S_W_MRD3`, then `S_READY`.
- `S_READY` holds until reset.

Every wait state leaves when the timer reads zero.

Top module: `ddr_init_seq`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) puts the block in idle, even in the middle of a run. In idle, `cke` is 0, `done` is 0, `ba` and `addr` are all zeros, and the command bus {cs_n,ras_n,cas_n,we_n} shows NOP = 4'b0111. The block stays idle until a start pulse.
- R2: Call the rising edge that samples `start` high in idle "edge 0". Clock interval k is the interval following edge k. `cke` is 0 for intervals 0 to T_PWR-1 and becomes 1 in interval T_PWR, while the bus shows NOP. `cke` never falls again before reset, and no command other than NOP appears while `cke` is 0.
- R3: The first precharge-all appears in interval T_PWR+1. It is encoded as 4'b0010 on the bus, with addr bit A10_BIT = 1, all other addr bits 0, and ba = 0.
- R4: A load-mode command (4'b0000) to the extended register follows T_RP cycles after the first precharge. It carries ba = 2'b01 and addr = EMR_VAL.
- R5: T_MRD cycles later, a load-mode command to the base register follows. It carries ba = 2'b00 and addr = MR_VAL with bit DLL_RST_BIT set.
- R6: A second precharge-all (encoded as in R3) follows T_MRD cycles after the base load. Auto refresh (4'b0001, ba = 0, addr = 0) follows T_RP cycles later. A second auto refresh follows T_RFC cycles after the first.
- R7: `dll_clear` is sampled with start. If it was 1, a base-register load (ba = 0, addr = MR_VAL with bit DLL_RST_BIT cleared) follows T_RFC cycles after the second refresh, and `done` rises T_MRD cycles after that load. If it was 0, `done` rises T_RFC cycles after the second refresh. `done` is 0 in the interval before it rises.
- R8: Each command lasts exactly one cycle, and the script issues exactly the commands listed in R3 to R7. Once `done` is 1, it stays 1 with `cke` = 1 and NOP on the bus until reset.
- R9: A `start` pulse outside idle has no effect, and a change of `dll_clear` after start has no effect. The command times, the command values and the `done` time stay as R3 to R7 give them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins the sequence when the block is idle |
| dll_clear | input | 1 | Selects the final DLL-reset-clear load; sampled with start |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address / mode register select |
| addr | output | ADDR_W | Address bus / mode register value |
| done | output | 1 | Device ready for normal commands |

## Verification
The script is run twice, once with the DLL-clear option set and once with it clear. This separates the two endings: one ends in an extra base load with a later ready flag, and the other makes the ready flag follow the second refresh directly. A scoreboard records every non-NOP bus cycle. It compares each one against the expected command, bank, address and cycle number, so wrong spacing, wrong order, missing commands and extra commands all show. During a run, a stray start pulse and a flip of the option input show whether the script stays on its course. A reset that arrives after the first precharge shows that the block returns to idle in the middle of a run.

// File: rtl/ddr_init_pkg.sv
`timescale 1ns/1ps
package ddr_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRE,
        CMD_REF,
        CMD_LMR
    } cmd_e;

    typedef enum logic [4:0] {
        S_IDLE,
        S_PWR_WAIT,
        S_CKE_ON,
        S_PRE1,
        S_W_RP1,
        S_LD_EMR,
        S_W_MRD1,
        S_LD_MR_RST,
        S_W_MRD2,
        S_PRE2,
        S_W_RP2,
        S_REF1,
        S_W_RFC1,
        S_REF2,
        S_W_RFC2,
        S_LD_MR_CLR,
        S_W_MRD3,
        S_READY
    } st_e;

endpackage

// File: rtl/init_wait_timer.sv
`timescale 1ns/1ps
module init_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/init_cmd_drive.sv
`timescale 1ns/1ps
module init_cmd_drive
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  cmd_e              cmd,
    input  logic [BA_W-1:0]   ba_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);

    always_comb begin
        unique case (cmd)
            CMD_PRE: {cs_n, ras_n, cas_n, we_n} = 4'b0010;
            CMD_REF: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            CMD_LMR: {cs_n, ras_n, cas_n, we_n} = 4'b0000;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
        endcase
        ba   = (cmd == CMD_NOP) ? '0 : ba_in;
        addr = (cmd == CMD_NOP) ? '0 : addr_in;
    end

endmodule

// File: rtl/ddr_init_seq.sv
`timescale 1ns/1ps
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int T_PWR       = 40000,
    parameter int T_RP        = 3,
    parameter int T_MRD       = 2,
    parameter int T_RFC       = 15,
    parameter int ADDR_W      = 13,
    parameter int BA_W        = 2,
    parameter int A10_BIT     = 10,
    parameter int DLL_RST_BIT = 8,
    parameter logic [ADDR_W-1:0] MR_VAL  = 13'h0061,
    parameter logic [ADDR_W-1:0] EMR_VAL = 13'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dll_clear,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);

    localparam int MAX_A = (T_PWR > T_RFC) ? T_PWR : T_RFC;
    localparam int MAX_B = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_T + 1);
    localparam logic [ADDR_W-1:0] DLL_MASK = ADDR_W'(1) << DLL_RST_BIT;
    localparam logic [ADDR_W-1:0] A10_MASK = ADDR_W'(1) << A10_BIT;

    st_e              state_q, state_d;
    logic             clr_q;
    logic             tmr_zero;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    cmd_e             cmd;
    logic [BA_W-1:0]  ba_sel;
    logic [ADDR_W-1:0] addr_val;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            clr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start) begin
                clr_q <= dll_clear;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start)    state_d = S_PWR_WAIT;
            S_PWR_WAIT:  if (tmr_zero) state_d = S_CKE_ON;
            S_CKE_ON:                  state_d = S_PRE1;
            S_PRE1:                    state_d = S_W_RP1;
            S_W_RP1:     if (tmr_zero) state_d = S_LD_EMR;
            S_LD_EMR:                  state_d = S_W_MRD1;
            S_W_MRD1:    if (tmr_zero) state_d = S_LD_MR_RST;
            S_LD_MR_RST:               state_d = S_W_MRD2;
            S_W_MRD2:    if (tmr_zero) state_d = S_PRE2;
            S_PRE2:                    state_d = S_W_RP2;
            S_W_RP2:     if (tmr_zero) state_d = S_REF1;
            S_REF1:                    state_d = S_W_RFC1;
            S_W_RFC1:    if (tmr_zero) state_d = S_REF2;
            S_REF2:                    state_d = S_W_RFC2;
            S_W_RFC2:    if (tmr_zero) state_d = clr_q ? S_LD_MR_CLR : S_READY;
            S_LD_MR_CLR:               state_d = S_W_MRD3;
            S_W_MRD3:    if (tmr_zero) state_d = S_READY;
            S_READY:                   state_d = S_READY;
            default:                   state_d = S_IDLE;
        endcase
    end

    // timer reload on every state change; wait states span (spacing - 1) cycles
    assign tmr_load = (state_d != state_q);

    always_comb begin
        unique case (state_d)
            S_PWR_WAIT:                   tmr_val = CNT_W'(T_PWR - 1);
            S_W_RP1, S_W_RP2:             tmr_val = CNT_W'(T_RP - 2);
            S_W_MRD1, S_W_MRD2, S_W_MRD3: tmr_val = CNT_W'(T_MRD - 2);
            S_W_RFC1, S_W_RFC2:           tmr_val = CNT_W'(T_RFC - 2);
            default:                      tmr_val = '0;
        endcase
    end

    init_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // outputs
    always_comb begin
        cmd      = CMD_NOP;
        ba_sel   = '0;
        addr_val = '0;
        cke      = !(state_q == S_IDLE || state_q == S_PWR_WAIT);
        done     = (state_q == S_READY);
        unique case (state_q)
            S_PRE1, S_PRE2: begin
                cmd      = CMD_PRE;
                addr_val = A10_MASK;
            end
            S_LD_EMR: begin
                cmd      = CMD_LMR;
                ba_sel   = BA_W'(1);
                addr_val = EMR_VAL;
            end
            S_LD_MR_RST: begin
                cmd      = CMD_LMR;
                addr_val = MR_VAL | DLL_MASK;
            end
            S_LD_MR_CLR: begin
                cmd      = CMD_LMR;
                addr_val = MR_VAL & ~DLL_MASK;
            end
            S_REF1, S_REF2: cmd = CMD_REF;
            default: ;
        endcase
    end

    init_cmd_drive #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_drive (
        .cmd     (cmd),
        .ba_in   (ba_sel),
        .addr_in (addr_val),
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .ba      (ba),
        .addr    (addr)
    );

    // R2: no command while clock enable is low
    a_r2_quiet_while_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

    // R2: clock enable never drops again before reset
    a_r2_cke_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    // R8: each command lasts one cycle
    a_r8_single_cycle_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} != 4'b0111) |=> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

    // R8: ready flag is sticky
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R8: ready state keeps the bus idle with clock enabled
    a_r8_ready_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cke && {cs_n, ras_n, cas_n, we_n} == 4'b0111));

    // R9: option latched at start does not move during a run
    a_r9_option_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && $past(cke)) |-> $stable(clr_q));

endmodule

// File: tb/ddr_init_seq_test.sv
`timescale 1ns/1ps
module ddr_init_seq_test;

    localparam int TP  = 20;
    localparam int TRP = 3;
    localparam int TMD = 2;
    localparam int TRF = 7;
    localparam logic [12:0] MRV  = 13'h0061;
    localparam logic [12:0] EMRV = 13'h0002;
    localparam logic [12:0] DLLM = 13'h0100;
    localparam logic [12:0] A10M = 13'h0400;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, start, dll_clear;
    logic cke, cs_n, ras_n, cas_n, we_n, done;
    logic [1:0]  ba;
    logic [12:0] addr;

    ddr_init_seq #(
        .T_PWR(TP), .T_RP(TRP), .T_MRD(TMD), .T_RFC(TRF),
        .ADDR_W(13), .BA_W(2), .A10_BIT(10), .DLL_RST_BIT(8),
        .MR_VAL(MRV), .EMR_VAL(EMRV)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dll_clear(dll_clear),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .done(done)
    );

    typedef struct {
        int          t;
        logic [3:0]  c;
        logic [1:0]  b;
        logic [12:0] a;
        string       req;
    } item_t;

    item_t exp_q[$];
    int  tick = 0;
    int  n_chk = 0;
    int  n_bad = 0;
    bit  mon_on = 1'b0;
    bit  fin = 1'b0;

    always @(posedge clk) tick = tick + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic push(input int t, input logic [3:0] c, input logic [1:0] b,
                        input logic [12:0] a, input string req);
        item_t it;
        it.t = t; it.c = c; it.b = b; it.a = a; it.req = req;
        exp_q.push_back(it);
    endtask

    // driver side of the scoreboard: expected command script
    task automatic load_expect(input int t0, input bit clr, output int t_done);
        int tp1, te, tm, tp2, tr1, tr2;
        tp1 = t0 + TP + 1;
        te  = tp1 + TRP;
        tm  = te + TMD;
        tp2 = tm + TMD;
        tr1 = tp2 + TRP;
        tr2 = tr1 + TRF;
        push(tp1, 4'b0010, 2'b00, A10M, "R3");
        push(te,  4'b0000, 2'b01, EMRV, "R4");
        push(tm,  4'b0000, 2'b00, MRV | DLLM, "R5");
        push(tp2, 4'b0010, 2'b00, A10M, "R6");
        push(tr1, 4'b0001, 2'b00, 13'h0, "R6");
        push(tr2, 4'b0001, 2'b00, 13'h0, "R6");
        if (clr) begin
            push(tr2 + TRF, 4'b0000, 2'b00, MRV & ~DLLM, "R7");
            t_done = tr2 + TRF + TMD;
        end else begin
            t_done = tr2 + TRF;
        end
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (mon_on && rst_n === 1'b1) begin
            logic [3:0] bus;
            bus = {cs_n, ras_n, cas_n, we_n};
            if (bus !== 4'b0111) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected command", int'(bus), 7);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(tick == it.t, it.req, "command cycle", tick, it.t);
                    chk(bus === it.c, it.req, "command code", int'(bus), int'(it.c));
                    chk(ba === it.b, it.req, "bank", int'(ba), int'(it.b));
                    chk(addr === it.a, it.req, "address", int'(addr), int'(it.a));
                end
            end
        end
    end

    task automatic wait_to(input int t);
        while (tick < t) @(negedge clk);
    endtask

    task automatic check_idle(input string req);
        chk(cke === 1'b0, req, "cke idle", int'(cke), 0);
        chk({cs_n, ras_n, cas_n, we_n} === 4'b0111, req, "bus idle",
            int'({cs_n, ras_n, cas_n, we_n}), 7);
        chk(done === 1'b0, req, "done idle", int'(done), 0);
        chk(ba === 2'b00 && addr === 13'h0, req, "ba/addr idle", int'({ba, addr}), 0);
    endtask

    task automatic run(input bit clr);
        int t0, td;
        dll_clear = clr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t0 = tick;
        load_expect(t0, clr, td);
        mon_on = 1'b1;
        wait_to(t0 + TP - 1);
        chk(cke === 1'b0, "R2", "cke before power wait ends", int'(cke), 0);
        wait_to(t0 + TP);
        chk(cke === 1'b1, "R2", "cke raised", int'(cke), 1);
        chk({cs_n, ras_n, cas_n, we_n} === 4'b0111, "R2", "nop with cke rise",
            int'({cs_n, ras_n, cas_n, we_n}), 7);
        wait_to(t0 + TP + 5);
        start = 1'b1;           // R9: stray start mid-run
        dll_clear = ~clr;       // R9: option change after start
        @(negedge clk);
        start = 1'b0;
        wait_to(td - 1);
        chk(done === 1'b0, "R7", "done before final wait", int'(done), 0);
        wait_to(td);
        chk(done === 1'b1, "R7", "done at final wait end", int'(done), 1);
        repeat (6) @(negedge clk);
        chk(done === 1'b1 && cke === 1'b1, "R8", "done/cke held", int'({done, cke}), 3);
        chk(exp_q.size() == 0, "R8", "commands left unissued", exp_q.size(), 0);
        exp_q.delete();
        mon_on = 1'b0;
    endtask

    initial begin
        int t0;
        rst_n = 1'b0;
        start = 1'b0;
        dll_clear = 1'b0;
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_idle("R1");

        run(1'b1);

        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);

        run(1'b0);

        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset in the middle of a run
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t0 = tick;
        wait_to(t0 + TP + 3);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("R1");

        fin = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20000 * 5);
        if (!fin) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule